// File: doc/BRIEF.md
# Delayed Read Request Tracker

This block sits behind the target side of a PCI-style bus and turns read attempts from external masters into delayed transactions. The first time a master issues a claimed read, the tracker records its command and address in one of two request slots and answers with a retry. The master must come back later with the identical command and address. Meanwhile the tracker hands the oldest recorded request to an internal-bus read engine, which fills a single shared data buffer.

Only the oldest slot ever owns the buffer. When a matching attempt finds the buffer complete, the tracker answers with a data response and streams the buffered words, one per cycle. The master may end the burst early, and whatever is left in the buffer is then thrown away. Only after that does the second slot's read start on the internal bus. An internal-bus error recorded during the fill is reported as a target abort to the matching attempt, and no data is sent.

Top module: `drt_tracker`

## Requirements
- R1: After reset both slots are empty, `rsp` is 0 (none), and `ib_req` and `cpl_valid` are low.
- R2: Only command codes 4'h6 (memory read), 4'hE (memory read line), 4'hC (memory read multiple) and 4'hA (configuration read) are claimed. Any other code gets `rsp` 0 (none) and is not recorded.
- R3: A claimed attempt that matches no slot is recorded in a free slot and answered with `rsp` 1 (retry). If both slots are busy, it is answered with retry and not recorded.
- R4: An attempt matches a slot only when both its command and its address equal the stored ones. The same address with a different command is a new request.
- R5: `ib_req` presents only the oldest slot's command and address, and stays stable until `ib_ack`. The younger slot's read is not requested until the oldest slot has been released.
- R6: `ib_len` gives the prefetch size in beats: DEPTH for 4'hC, DEPTH/2 for 4'hE, and 1 for 4'h6 and 4'hA.
- R7: An attempt that matches a slot whose data is not complete, or that matches the younger slot, is answered with retry.
- R8: An attempt that matches the oldest slot after its fill finished answers `rsp` 2 (data). From the next cycle, the buffered words are driven on `cpl_data` in fill order, one per cycle, with `cpl_last` on the final word.
- R9: When `req_stop` is raised during a burst, no word is sent in that cycle, the remaining words are discarded, and the slot is freed.
- R10: An internal-bus beat flagged `ib_err` marks the oldest slot as failed. Its matching attempt gets `rsp` 3 (abort), the slot is freed, and no word is delivered.
- R11: Fill beats beyond DEPTH words are dropped, so a burst delivers at most DEPTH words.
- R12: A claimed attempt that arrives while a burst is in progress is answered with retry and is not recorded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | A read attempt is present this cycle |
| req_cmd | input | 4 | Bus command of the attempt |
| req_addr | input | ADDR_W | Address of the attempt |
| req_stop | input | 1 | Master ends the current data burst |
| rsp | output | 2 | Answer to the attempt: 0 none, 1 retry, 2 data, 3 abort |
| cpl_valid | output | 1 | A data word is delivered this cycle |
| cpl_data | output | DATA_W | Delivered word |
| cpl_last | output | 1 | Delivered word is the last one buffered |
| ib_req | output | 1 | Internal read request for the oldest slot |
| ib_cmd | output | 4 | Command of the requested read |
| ib_addr | output | ADDR_W | Address of the requested read |
| ib_len | output | clog2(DEPTH+1) | Prefetch size in beats |
| ib_ack | input | 1 | Engine accepts the request |
| ib_dvalid | input | 1 | Fill beat valid |
| ib_data | input | DATA_W | Fill beat data |
| ib_last | input | 1 | Final fill beat |
| ib_err | input | 1 | Fill beat carries an internal-bus error |

## Verification
The bench builds the tracker with DEPTH set to 4 and ADDR_W set to 16. With these values, the line read asks for 2 beats and the multiple read asks for 4, so a six-beat fill overruns the buffer within a few cycles. This makes the drop rule, early stops in the middle of a burst and the full-slot refusal all reachable in short sequences. A 32-bit data width keeps each delivered word distinct for checking the delivery order.

// File: rtl/drt_pkg.sv
package drt_pkg;

  typedef enum logic [1:0] {
    RSP_NONE  = 2'd0,
    RSP_RETRY = 2'd1,
    RSP_DATA  = 2'd2,
    RSP_ABORT = 2'd3
  } rsp_e;

  typedef enum logic [2:0] {
    PH_WAIT,
    PH_FILL,
    PH_READY,
    PH_ERR,
    PH_DRAIN
  } phase_e;

  localparam logic [3:0] CMD_MRD  = 4'h6;
  localparam logic [3:0] CMD_CRD  = 4'hA;
  localparam logic [3:0] CMD_MRDM = 4'hC;
  localparam logic [3:0] CMD_MRDL = 4'hE;

  function automatic logic is_claimed(input logic [3:0] c);
    return (c == CMD_MRD) || (c == CMD_CRD) || (c == CMD_MRDM) || (c == CMD_MRDL);
  endfunction

  function automatic int unsigned prefetch_beats(input logic [3:0] c, input int unsigned depth);
    if (c == CMD_MRDM) return depth;
    if (c == CMD_MRDL) return depth / 2;
    return 1;
  endfunction

endpackage

// File: rtl/drt_slot.sv
module drt_slot #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              clear,
  input  logic [3:0]        ld_cmd,
  input  logic [ADDR_W-1:0] ld_addr,
  input  logic [3:0]        cmp_cmd,
  input  logic [ADDR_W-1:0] cmp_addr,
  output logic              occupied,
  output logic              hit,
  output logic [3:0]        cmd,
  output logic [ADDR_W-1:0] addr
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      occupied <= 1'b0;
      cmd      <= '0;
      addr     <= '0;
    end else if (load) begin
      occupied <= 1'b1;
      cmd      <= ld_cmd;
      addr     <= ld_addr;
    end else if (clear) begin
      occupied <= 1'b0;
    end
  end

  assign hit = occupied && (cmd == cmp_cmd) && (addr == cmp_addr);

endmodule

// File: rtl/drt_buf.sv
module drt_buf #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic [DATA_W-1:0]          wr_data,
  input  logic                       rd_adv,
  input  logic                       flush,
  output logic [DATA_W-1:0]          rd_data,
  output logic                       rd_last,
  output logic [$clog2(DEPTH+1)-1:0] count
);

  localparam int PTR_W = $clog2(DEPTH);
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  rd_idx;
  logic              full;

  assign full    = (count == CNT_W'(DEPTH));
  assign rd_data = mem[rd_idx];
  assign rd_last = ((CNT_W'(rd_idx) + CNT_W'(1)) == count);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count  <= '0;
      rd_idx <= '0;
    end else if (flush) begin
      count  <= '0;
      rd_idx <= '0;
    end else begin
      if (wr_en && !full) count <= count + CNT_W'(1);
      if (rd_adv) rd_idx <= rd_idx + PTR_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en && !full) mem[count[PTR_W-1:0]] <= wr_data;
  end

endmodule

// File: rtl/drt_tracker.sv
module drt_tracker
  import drt_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int DEPTH  = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       req_valid,
  input  logic [3:0]                 req_cmd,
  input  logic [ADDR_W-1:0]          req_addr,
  input  logic                       req_stop,
  output logic [1:0]                 rsp,
  output logic                       cpl_valid,
  output logic [DATA_W-1:0]          cpl_data,
  output logic                       cpl_last,
  output logic                       ib_req,
  output logic [3:0]                 ib_cmd,
  output logic [ADDR_W-1:0]          ib_addr,
  output logic [$clog2(DEPTH+1)-1:0] ib_len,
  input  logic                       ib_ack,
  input  logic                       ib_dvalid,
  input  logic [DATA_W-1:0]          ib_data,
  input  logic                       ib_last,
  input  logic                       ib_err
);

  localparam int NSLOT = 2;
  localparam int LEN_W = $clog2(DEPTH + 1);

  logic [NSLOT-1:0] slot_occ, slot_hit, load_vec, clear_vec;
  logic [3:0]       slot_cmd  [NSLOT];
  logic [ADDR_W-1:0] slot_addr [NSLOT];

  logic   head;
  phase_e phase, phase_nx;
  rsp_e   rsp_w;

  logic claimed, head_hit, other_hit, cap_en, cap_slot;
  logic drain_on, drain_done, abort_take, release_head, fill_beat;
  logic buf_rd_last;
  logic [LEN_W-1:0] buf_count;

  for (genvar g = 0; g < NSLOT; g++) begin : g_slot
    drt_slot #(.ADDR_W(ADDR_W)) u_slot (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (load_vec[g]),
      .clear    (clear_vec[g]),
      .ld_cmd   (req_cmd),
      .ld_addr  (req_addr),
      .cmp_cmd  (req_cmd),
      .cmp_addr (req_addr),
      .occupied (slot_occ[g]),
      .hit      (slot_hit[g]),
      .cmd      (slot_cmd[g]),
      .addr     (slot_addr[g])
    );
    assign load_vec[g]  = cap_en && (cap_slot == 1'(g));
    assign clear_vec[g] = release_head && (head == 1'(g));
  end

  assign claimed   = req_valid && is_claimed(req_cmd);
  assign head_hit  = slot_hit[head];
  assign other_hit = slot_hit[~head];
  assign drain_on  = (phase == PH_DRAIN);

  always_comb begin
    rsp_w = RSP_NONE;
    if (claimed) begin
      if (drain_on)                            rsp_w = RSP_RETRY;
      else if (head_hit && phase == PH_READY) rsp_w = RSP_DATA;
      else if (head_hit && phase == PH_ERR)   rsp_w = RSP_ABORT;
      else                                     rsp_w = RSP_RETRY;
    end
  end
  assign rsp = rsp_w;

  assign cap_en   = claimed && !drain_on && !head_hit && !other_hit && !(&slot_occ);
  assign cap_slot = slot_occ[head] ? ~head : head;

  assign cpl_valid    = drain_on && !req_stop;
  assign cpl_last     = drain_on && buf_rd_last;
  assign drain_done   = drain_on && (req_stop || buf_rd_last);
  assign abort_take   = (rsp_w == RSP_ABORT);
  assign release_head = drain_done || abort_take;

  assign ib_req    = slot_occ[head] && (phase == PH_WAIT);
  assign ib_cmd    = slot_cmd[head];
  assign ib_addr   = slot_addr[head];
  assign ib_len    = LEN_W'(prefetch_beats(slot_cmd[head], DEPTH));
  assign fill_beat = (phase == PH_FILL) && ib_dvalid;

  drt_buf #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_buf (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (fill_beat && !ib_err),
    .wr_data (ib_data),
    .rd_adv  (cpl_valid && !buf_rd_last),
    .flush   (release_head),
    .rd_data (cpl_data),
    .rd_last (buf_rd_last),
    .count   (buf_count)
  );

  always_comb begin
    phase_nx = phase;
    unique case (phase)
      PH_WAIT:  if (ib_req && ib_ack) phase_nx = PH_FILL;
      PH_FILL:  if (ib_dvalid) phase_nx = ib_err ? PH_ERR : (ib_last ? PH_READY : PH_FILL);
      PH_READY: if (rsp_w == RSP_DATA) phase_nx = PH_DRAIN;
      PH_ERR:   if (abort_take) phase_nx = PH_WAIT;
      PH_DRAIN: if (drain_done) phase_nx = PH_WAIT;
      default:  phase_nx = PH_WAIT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_WAIT;
      head  <= 1'b0;
    end else begin
      phase <= phase_nx;
      if (release_head) head <= ~head;
    end
  end

endmodule

// File: rtl/drt_checks.sv
module drt_checks
  import drt_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DEPTH  = 8
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       req_valid,
  input logic [1:0]                 rsp,
  input logic                       cpl_valid,
  input logic                       cpl_last,
  input logic                       ib_req,
  input logic                       ib_ack,
  input logic [ADDR_W-1:0]          ib_addr,
  input logic                       in_drain,
  input logic [1:0]                 load_vec,
  input logic [$clog2(DEPTH+1)-1:0] buf_count
);

  assert_capture_retry_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (load_vec != 2'b00) |-> ($onehot0(load_vec) && rsp == RSP_RETRY));

  assert_hold_request_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ib_req && !ib_ack) |=> (ib_req && $stable(ib_addr)));

  assert_no_fetch_in_burst_R5: assert property (@(posedge clk) disable iff (!rst_n)
    in_drain |-> !ib_req);

  assert_burst_continues_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cpl_valid && !cpl_last) |=> in_drain);

  assert_no_data_after_abort_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp == RSP_ABORT) |=> !cpl_valid);

  assert_no_overflow_R11: assert property (@(posedge clk) disable iff (!rst_n)
    buf_count <= ($clog2(DEPTH+1))'(DEPTH));

  assert_busy_retry_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (in_drain && req_valid && rsp != RSP_NONE) |-> (rsp == RSP_RETRY && load_vec == 2'b00));

endmodule

bind drt_tracker drt_checks #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) u_checks (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .rsp       (rsp),
  .cpl_valid (cpl_valid),
  .cpl_last  (cpl_last),
  .ib_req    (ib_req),
  .ib_ack    (ib_ack),
  .ib_addr   (ib_addr),
  .in_drain  (drain_on),
  .load_vec  (load_vec),
  .buf_count (buf_count)
);

// File: tb/test_drt_tracker.sv
`timescale 1ns/1ps
module test_drt_tracker;
  localparam int AW = 16;
  localparam int DW = 32;
  localparam int DEPTH = 4;
  localparam int LW = $clog2(DEPTH + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 0, req_stop = 0;
  logic [3:0] req_cmd = 0;
  logic [AW-1:0] req_addr = 0;
  logic ib_ack = 0, ib_dvalid = 0, ib_last = 0, ib_err = 0;
  logic [DW-1:0] ib_data = 0;
  logic [1:0] rsp;
  logic cpl_valid, cpl_last, ib_req;
  logic [DW-1:0] cpl_data;
  logic [3:0] ib_cmd;
  logic [AW-1:0] ib_addr;
  logic [LW-1:0] ib_len;

  always #2.5 clk = ~clk;

  drt_tracker #(.ADDR_W(AW), .DATA_W(DW), .DEPTH(DEPTH)) i_drt_tracker (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_cmd(req_cmd),
    .req_addr(req_addr), .req_stop(req_stop), .rsp(rsp), .cpl_valid(cpl_valid),
    .cpl_data(cpl_data), .cpl_last(cpl_last), .ib_req(ib_req), .ib_cmd(ib_cmd),
    .ib_addr(ib_addr), .ib_len(ib_len), .ib_ack(ib_ack), .ib_dvalid(ib_dvalid),
    .ib_data(ib_data), .ib_last(ib_last), .ib_err(ib_err)
  );

  int checks = 0, errors = 0, cycles = 0;
  bit done = 0;
  string tag = "R1";

  // Behavioural reference: phase 0 wait, 1 fill, 2 ready, 3 error, 4 burst
  bit m_occ [2];
  logic [3:0] m_cmd [2];
  logic [AW-1:0] m_addr [2];
  int m_head = 0, m_ph = 0, m_rd = 0;
  logic [DW-1:0] m_q [$];

  function automatic bit m_claim(logic [3:0] c);
    return c == 4'h6 || c == 4'hA || c == 4'hC || c == 4'hE;
  endfunction
  function automatic int m_len(logic [3:0] c);
    if (c == 4'hC) return DEPTH;
    if (c == 4'hE) return DEPTH / 2;
    return 1;
  endfunction
  function automatic bit m_hit(int i);
    return m_occ[i] && m_cmd[i] == req_cmd && m_addr[i] == req_addr;
  endfunction
  function automatic int m_rsp();
    if (!req_valid || !m_claim(req_cmd)) return 0;
    if (m_ph == 4) return 1;
    if (m_hit(m_head) && m_ph == 2) return 2;
    if (m_hit(m_head) && m_ph == 3) return 3;
    return 1;
  endfunction

  task automatic chk(bit ok, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h t=%0t", tag, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      automatic bit e_req = m_occ[m_head] && m_ph == 0;
      automatic bit e_cpl = m_ph == 4 && !req_stop;
      chk(rsp == 2'(m_rsp()), "rsp", rsp, m_rsp());
      chk(ib_req == e_req, "ib_req", ib_req, e_req);
      chk(cpl_valid == e_cpl, "cpl_valid", cpl_valid, e_cpl);
      if (e_req) begin
        chk(ib_cmd == m_cmd[m_head], "ib_cmd", ib_cmd, m_cmd[m_head]);
        chk(ib_addr == m_addr[m_head], "ib_addr", ib_addr, m_addr[m_head]);
        chk(ib_len == LW'(m_len(m_cmd[m_head])), "ib_len (R6)", ib_len, m_len(m_cmd[m_head]));
      end
      if (e_cpl) begin
        chk(cpl_data == m_q[m_rd], "cpl_data", cpl_data, m_q[m_rd]);
        chk(cpl_last == (m_rd == m_q.size() - 1), "cpl_last", cpl_last, m_rd == m_q.size() - 1);
      end
    end
  end

  always @(posedge clk) begin
    if (!rst_n) begin
      m_occ = '{0, 0}; m_head = 0; m_ph = 0; m_rd = 0; m_q.delete();
    end else begin
      automatic int r = m_rsp();
      automatic bit cap = r == 1 && m_ph != 4 && !m_hit(0) && !m_hit(1) && !(m_occ[0] && m_occ[1]);
      automatic int s = m_occ[m_head] ? 1 - m_head : m_head;
      automatic bit rel = 0;
      case (m_ph)
        0: if (m_occ[m_head] && ib_ack) m_ph = 1;
        1: if (ib_dvalid) begin
             if (ib_err) m_ph = 3;
             else begin
               if (m_q.size() < DEPTH) m_q.push_back(ib_data);
               if (ib_last) m_ph = 2;
             end
           end
        2: if (r == 2) begin m_ph = 4; m_rd = 0; end
        3: if (r == 3) rel = 1;
        default: if (req_stop || m_rd == m_q.size() - 1) rel = 1; else m_rd++;
      endcase
      if (rel) begin
        m_occ[m_head] = 0; m_head = 1 - m_head; m_q.delete(); m_rd = 0; m_ph = 0;
      end
      if (cap) begin m_occ[s] = 1; m_cmd[s] = req_cmd; m_addr[s] = req_addr; end
    end
  end

  task automatic cyc();
    @(posedge clk); #1;
  endtask

  task automatic attempt(logic [3:0] c, logic [AW-1:0] a);
    req_valid = 1; req_cmd = c; req_addr = a;
    cyc();
    req_valid = 0;
  endtask

  task automatic serve(int n, int err_at, logic [DW-1:0] base);
    for (int w = 0; w < 50 && !ib_req; w++) cyc();
    ib_ack = 1; cyc(); ib_ack = 0;
    for (int i = 0; i < n; i++) begin
      ib_dvalid = 1; ib_data = base + DW'(i); ib_last = (i == n - 1); ib_err = (i == err_at);
      cyc();
      ib_dvalid = 0; ib_last = 0; ib_err = 0;
      if (i == err_at) break;
    end
    cyc();
  endtask

  task automatic burst(int stop_at);
    for (int k = 0; k < 20; k++) begin
      req_stop = (k == stop_at);
      cyc();
      req_stop = 0;
      if (m_ph != 4) break;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      errors++;
      $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    tag = "R1";
    #1 chk(rsp == 0 && !ib_req && !cpl_valid, "R1 reset outputs", {rsp, ib_req, cpl_valid}, 0);
    cyc();
    tag = "R2"; attempt(4'h2, 16'h0100);
    chk(!ib_req, "R2 unclaimed not recorded", ib_req, 0);
    tag = "R3"; attempt(4'h6, 16'h0040);
    tag = "R6"; cyc();
    tag = "R7"; attempt(4'h6, 16'h0040);
    tag = "R4"; attempt(4'hE, 16'h0040);
    tag = "R3"; attempt(4'hC, 16'h0080);
    tag = "R5"; serve(1, -1, 32'hA000_0000);
    tag = "R7"; attempt(4'hE, 16'h0040);
    tag = "R8"; attempt(4'h6, 16'h0040); burst(-1);
    tag = "R5"; serve(2, -1, 32'hB000_0000);
    tag = "R8"; attempt(4'hE, 16'h0040);
    tag = "R12"; req_valid = 1; req_cmd = 4'hC; req_addr = 16'h0080; cyc(); req_valid = 0;
    burst(-1);
    chk(!ib_req, "R12 busy attempt not recorded", ib_req, 0);
    tag = "R9"; attempt(4'hC, 16'h0080); serve(4, -1, 32'hC000_0000);
    attempt(4'hC, 16'h0080); burst(1);
    tag = "R11"; attempt(4'hC, 16'h0080); serve(6, -1, 32'hD000_0000);
    attempt(4'hC, 16'h0080); burst(-1);
    tag = "R10"; attempt(4'hA, 16'h0010); serve(3, 1, 32'hE000_0000);
    attempt(4'hA, 16'h0010); cyc(); cyc();
    tag = "R2"; attempt(4'h7, 16'h0010); cyc();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule